// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block sits beside a single DMA channel and turns its terminating events into a prioritised interrupt request. Four event flags come straight from the DMA engine (local bus error, chain interrupt, timeout and done). A fifth source is a device-terminated flag kept inside the block. That flag sets when the attached device signals end of transfer while the end-of-transfer interrupt option is on, and it is cleared when software starts DMA again. While any of the five sources is high, a sticky status bit is set.

Software reaches the block over a byte-wide register port with two registers. The control register holds the status bit, an interrupt enable, a write-one clear command and a three-bit priority level. The DMA enable register holds one run bit. The interrupt output is a registered three-bit level bus. It carries the programmed level while status and enable are both set and the level is non-zero. Otherwise it is zero.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset every register bit, the device-terminated flag, `dma_en_o` and `irq_lvl_o` are 0, and both registers read 0.
- R2: The control register is at offset 0. Bits 2:0 hold the level and bit 4 the enable, and both are read/write. Bits 6:5 and bit 3 always read as 0.
- R3: Status is bit 7 of the control register and is read-only. Writing 1 to bit 7 never sets it.
- R4: Status sets on the clock edge after a cycle in which any source is high. Input `evt_i` bit 0 is local bus error, bit 1 chain interrupt, bit 2 timeout and bit 3 done. The fifth source is the device-terminated flag.
- R5: A control write with bit 3 at 1 clears status on that edge when no source is high. A write with bit 3 at 0 leaves status unchanged.
- R6: If a source is high in the same cycle as a clear command, status stays set.
- R7: `irq_lvl_o` equals the level field one clock after status, enable and a non-zero level all hold. In every other case it is 0.
- R8: With the enable bit at 0, `irq_lvl_o` stays 0 while status still latches.
- R9: A level of 0 keeps `irq_lvl_o` at 0 even with status and enable set.
- R10: The device-terminated flag sets when `dev_end_i` and `dev_end_ien_i` are high in the same cycle. `dev_end_i` alone has no effect. Once set, the flag holds.
- R11: Writing 1 to bit 0 of the DMA enable register clears the device-terminated flag. Writing 0 leaves it set.
- R12: The DMA enable register is at offset 1. Bit 0 is read/write and drives `dma_en_o`, and bits 7:1 read 0. Writes with `cs` low have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port select |
| we | input | 1 | Write strobe, qualified by cs |
| addr | input | ADDR_W (2) | Register offset |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, combinational from addr while cs is high |
| evt_i | input | N_EVT (4) | Event flags from the DMA engine |
| dev_end_i | input | 1 | Device end-of-transfer signal |
| dev_end_ien_i | input | 1 | End-of-transfer interrupt option from DMA configuration |
| dev_term_o | output | 1 | Device-terminated flag |
| dma_en_o | output | 1 | DMA run bit |
| irq_lvl_o | output | LVL_W (3) | Interrupt priority level, 0 when idle |

## Verification
The bench builds the block with its default parameters: four external event inputs, a three-bit level, a two-bit offset and all sources enabled. Because this configuration is small, the bench can sweep all eight levels against both enable settings and compute the expected output level arithmetically for each pair. It also fires every one of the five sources on its own. Together these runs reach the clear/event collision, the hand-off of the device-terminated flag and the zero-level hold-off.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int STS_POS = 7;
   localparam int IEN_POS = 4;
   localparam int CLR_POS = 3;
   localparam int RUN_POS = 0;

   typedef enum int {
      SRC_BUS_ERR = 0,
      SRC_CHAIN   = 1,
      SRC_TIMEOUT = 2,
      SRC_DONE    = 3
   } evt_src_e;
endpackage

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int LVL_W  = 3,
   parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
   parameter logic [ADDR_W-1:0] RUN_OFS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sts,
   output logic              ien,
   output logic [LVL_W-1:0]  lvl,
   output logic              clr_cmd,
   output logic              run_start,
   output logic              run,
   output logic [DATA_W-1:0] rdata
);
   import dma_irq_pkg::*;

   logic wr_ctrl, wr_run;

   assign wr_ctrl   = cs && we && (addr == CTRL_OFS);
   assign wr_run    = cs && we && (addr == RUN_OFS);
   assign clr_cmd   = wr_ctrl && wdata[CLR_POS];
   assign run_start = wr_run && wdata[RUN_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien <= 1'b0;
         lvl <= '0;
         run <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ien <= wdata[IEN_POS];
            lvl <= wdata[LVL_W-1:0];
         end
         if (wr_run) run <= wdata[RUN_POS];
      end
   end

   always_comb begin
      rdata = '0;
      if (cs) begin
         if (addr == CTRL_OFS) begin
            rdata[STS_POS]     = sts;
            rdata[IEN_POS]     = ien;
            rdata[LVL_W-1:0]   = lvl;
         end else if (addr == RUN_OFS) begin
            rdata[RUN_POS] = run;
         end
      end
   end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
   parameter int N_EVT = 4,
   parameter logic [N_EVT:0] SRC_EN = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt,
   input  logic             dev_end,
   input  logic             dev_end_ien,
   input  logic             clr_cmd,
   input  logic             run_start,
   output logic             sts,
   output logic             dev_term
);
   logic [N_EVT:0] src_vec;
   logic [N_EVT:0] src_gated;
   logic           any_src;
   logic           term_set;

   assign term_set = dev_end && dev_end_ien;
   assign src_vec  = {dev_term, evt};

   for (genvar i = 0; i <= N_EVT; i++) begin : g_src
      if (SRC_EN[i]) begin : g_on
         assign src_gated[i] = src_vec[i];
      end else begin : g_off
         assign src_gated[i] = 1'b0;
      end
   end

   assign any_src = |src_gated;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_term <= 1'b0;
         sts      <= 1'b0;
      end else begin
         if (term_set)       dev_term <= 1'b1;
         else if (run_start) dev_term <= 1'b0;
         sts <= (sts && !clr_cmd) || any_src;
      end
   end
endmodule

// File: rtl/dma_irq_req.sv
module dma_irq_req #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sts,
   input  logic             ien,
   input  logic [LVL_W-1:0] lvl,
   output logic [LVL_W-1:0] irq_lvl
);
   logic             active;
   logic [LVL_W-1:0] lvl_next;

   assign active   = sts && ien && (lvl != '0);
   assign lvl_next = active ? lvl : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_lvl <= '0;
      else        irq_lvl <= lvl_next;
   end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int LVL_W  = 3,
   parameter int N_EVT  = 4,
   parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
   parameter logic [ADDR_W-1:0] RUN_OFS  = 1,
   parameter logic [N_EVT:0]    SRC_EN   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              dev_end_i,
   input  logic              dev_end_ien_i,
   output logic              dev_term_o,
   output logic              dma_en_o,
   output logic [LVL_W-1:0]  irq_lvl_o
);
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (LVL_W < 1 || LVL_W > 3) begin : g_bad_lvl
      $error("LVL_W must fit below the clear bit (1..3)");
   end
   if (N_EVT < 1) begin : g_bad_evt
      $error("N_EVT must be at least 1");
   end
   if (CTRL_OFS == RUN_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end

   logic             sts_q;
   logic             ien_q;
   logic [LVL_W-1:0] lvl_q;
   logic             clr_cmd;
   logic             run_start;

   dma_irq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
      .CTRL_OFS(CTRL_OFS), .RUN_OFS(RUN_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
      .sts(sts_q), .ien(ien_q), .lvl(lvl_q), .clr_cmd(clr_cmd),
      .run_start(run_start), .run(dma_en_o), .rdata(rdata)
   );

   dma_irq_status #(.N_EVT(N_EVT), .SRC_EN(SRC_EN)) u_status (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .dev_end(dev_end_i),
      .dev_end_ien(dev_end_ien_i), .clr_cmd(clr_cmd), .run_start(run_start),
      .sts(sts_q), .dev_term(dev_term_o)
   );

   dma_irq_req #(.LVL_W(LVL_W)) u_req (
      .clk(clk), .rst_n(rst_n), .sts(sts_q), .ien(ien_q), .lvl(lvl_q),
      .irq_lvl(irq_lvl_o)
   );
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int LVL_W  = 3,
   parameter int N_EVT  = 4,
   parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
   parameter logic [ADDR_W-1:0] RUN_OFS  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [N_EVT-1:0]  evt_i,
   input logic              dev_end_i,
   input logic              dev_end_ien_i,
   input logic              dev_term_o,
   input logic [LVL_W-1:0]  irq_lvl_o,
   input logic              sts,
   input logic              ien,
   input logic [LVL_W-1:0]  lvl
);
   logic ctrl_clr_wr, run_one_wr, term_in, no_src;

   assign ctrl_clr_wr = cs && we && (addr == CTRL_OFS) && wdata[3];
   assign run_one_wr  = cs && we && (addr == RUN_OFS) && wdata[0];
   assign term_in     = dev_end_i && dev_end_ien_i;
   assign no_src      = !(|evt_i) && !dev_term_o;

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && addr == CTRL_OFS) |-> (rdata[6:5] == 2'b00 && rdata[3] == 1'b0));
   assert_status_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts && no_src) |=> !sts);
   assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> sts);
   assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_clr_wr && no_src) |=> !sts);
   assert_no_event_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_clr_wr && (|evt_i)) |=> sts);
   assert_level_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts && ien && lvl != '0) |=> (irq_lvl_o == $past(lvl)));
   assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |=> (irq_lvl_o == '0));
   assert_level_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == '0) |=> (irq_lvl_o == '0));
   assert_term_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      term_in |=> dev_term_o);
   assert_term_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_one_wr && !term_in) |=> !dev_term_o);
endmodule

bind dma_irq_ctl dma_irq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .N_EVT(N_EVT),
   .CTRL_OFS(CTRL_OFS), .RUN_OFS(RUN_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
   .rdata(rdata), .evt_i(evt_i), .dev_end_i(dev_end_i),
   .dev_end_ien_i(dev_end_ien_i), .dev_term_o(dev_term_o),
   .irq_lvl_o(irq_lvl_o), .sts(sts_q), .ien(ien_q), .lvl(lvl_q)
);

// File: tb/sim_dma_irq_ctl.sv
module sim_dma_irq_ctl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, we = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] evt_i = '0;
   logic       dev_end_i = 1'b0, dev_end_ien_i = 1'b0;
   logic       dev_term_o, dma_en_o;
   logic [2:0] irq_lvl_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_irq_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .evt_i(evt_i), .dev_end_i(dev_end_i),
      .dev_end_ien_i(dev_end_ien_i), .dev_term_o(dev_term_o),
      .dma_en_o(dma_en_o), .irq_lvl_o(irq_lvl_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1; we = 1; addr = a; wdata = d;
      @(negedge clk);
      cs = 0; we = 0; wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1; we = 0; addr = a;
      #1 d = rdata;
      cs = 0;
   endtask

   task automatic pulse(input logic [3:0] m);
      @(negedge clk);
      evt_i = m;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 irq", irq_lvl_o, 0);
      check("R1 run", dma_en_o, 0);
      check("R1 term", dev_term_o, 0);
      rd(2'd0, d); check("R1 ctrl", d, 0);
      rd(2'd1, d); check("R1 run reg", d, 0);
      rst_n = 1;
      tick();

      // R2: fields read back, reserved bits and clear bit read 0
      wr(2'd0, 8'hFF);
      rd(2'd0, d); check("R2 ctrl readback", d, 8'h17);
      // R3: writing bit 7 did not set status
      check("R3 status ro", d[7], 0);
      wr(2'd0, 8'h80);
      rd(2'd0, d); check("R3 status ro 2", d, 8'h00);

      // R12: run register, unmapped offset, write without cs
      wr(2'd1, 8'hFF);
      rd(2'd1, d); check("R12 run reg", d, 8'h01);
      check("R12 run out", dma_en_o, 1);
      wr(2'd1, 8'h00);
      rd(2'd3, d); check("R12 unmapped", d, 0);
      @(negedge clk); cs = 0; we = 1; addr = 2'd0; wdata = 8'h15;
      @(negedge clk); we = 0; wdata = '0;
      rd(2'd0, d); check("R12 no cs", d, 0);

      // R4/R7/R8/R9: sweep level x enable, one source per pass
      for (int lv = 0; lv < 8; lv++) begin
         for (int en = 0; en < 2; en++) begin
            int exp_irq;
            wr(2'd0, 8'h08 | (en << 4) | lv);
            rd(2'd0, d); check("R5 cleared", d[7], 0);
            pulse(4'b0001 << (lv % 4));
            check("R7 latency", irq_lvl_o, 0);
            rd(2'd0, d); check("R4 status set", d[7], 1);
            exp_irq = (en == 1 && lv != 0) ? lv : 0;
            if (lv == 0) check("R9 zero level", irq_lvl_o, exp_irq);
            else if (en == 0) check("R8 masked", irq_lvl_o, exp_irq);
            else check("R7 level out", irq_lvl_o, exp_irq);
         end
      end

      // R5: write with clear bit 0 keeps status
      wr(2'd0, 8'h15);
      rd(2'd0, d); check("R5 no clear on 0", d[7], 1);
      wr(2'd0, 8'h1D);
      rd(2'd0, d); check("R5 clear on 1", d[7], 0);
      tick(); check("R7 idle", irq_lvl_o, 0);

      // R6: clear and event collide
      pulse(4'b1000);
      @(negedge clk);
      cs = 1; we = 1; addr = 2'd0; wdata = 8'h1D; evt_i = 4'b0100;
      @(negedge clk);
      cs = 0; we = 0; evt_i = '0;
      rd(2'd0, d); check("R6 no loss", d[7], 1);
      wr(2'd0, 8'h1D);

      // R10: dev_end without option ignored
      @(negedge clk); dev_end_i = 1; dev_end_ien_i = 0;
      @(negedge clk); dev_end_i = 0;
      check("R10 ignored", dev_term_o, 0);
      rd(2'd0, d); check("R10 no status", d[7], 0);
      // R10: with option, flag sets and feeds status
      @(negedge clk); dev_end_i = 1; dev_end_ien_i = 1;
      @(negedge clk); dev_end_i = 0; dev_end_ien_i = 0;
      check("R10 term set", dev_term_o, 1);
      tick();
      rd(2'd0, d); check("R4 term source", d[7], 1);
      wr(2'd0, 8'h1D);
      rd(2'd0, d); check("R11 flag keeps status", d[7], 1);
      // R11: writing 0 to run bit keeps flag
      wr(2'd1, 8'h00);
      check("R11 run 0 keeps", dev_term_o, 1);
      wr(2'd1, 8'h01);
      check("R11 run 1 clears", dev_term_o, 0);
      wr(2'd0, 8'h1D);
      rd(2'd0, d); check("R11 status clears", d[7], 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule